// File: doc/BRIEF.md
# Byte-Lane Register Bank

This block is a small bank of 16-bit control registers sitting behind a processor memory-bus slave port. The port accepts 8-bit and 16-bit transfers. Internally, a byte address becomes a word index plus a pair of byte-lane write enables, and only the enabled lanes of the selected register load on a write. An 8-bit store therefore cannot corrupt the neighbouring byte of the same register, whatever the host leaves on the unused half of the data bus.

The host drives a byte address, a size flag, write data, and single-cycle read and write strobes. A write takes effect on the rising edge where the write strobe is sampled high. A read is sampled on the same kind of edge. The result appears on the read-data port, together with a one-cycle valid pulse, after that edge. There are no wait states and no back-pressure: the slave is always ready, so every strobe is accepted in the cycle it is presented. Reads are not atomic across bytes. Two byte reads return the low and high halves of whatever the register holds at the moment of each read.

Top module: `blrb_bank`

## Requirements
- R1: After a synchronous reset every register holds 0x0000 and `bus_rvalid` is low.
- R2: A byte write (`bus_size`=0) with address bit 0 equal to 0 loads `bus_wdata[7:0]` into bits [7:0] of the addressed register. Bits [15:8] keep their value for any value on `bus_wdata[15:8]`.
- R3: A byte write with address bit 0 equal to 1 loads `bus_wdata[7:0]` into bits [15:8] of the addressed register. Bits [7:0] keep their value for any value on `bus_wdata[15:8]`.
- R4: A 16-bit write (`bus_size`=1) to an even address loads all of `bus_wdata[15:0]` into the register on a single edge.
- R5: A 16-bit access to an odd address is misaligned. As a write it changes no register. As a read it returns 0x0000.
- R6: Only word indices 0 to 7 (address bits [9:1]) are mapped. Writes to any other index change no register, including the register whose index matches in the low bits. Reads from any other index return 0x0000.
- R7: A byte read returns the addressed byte on `bus_rdata[7:0]` with bits [15:8] at zero. A 16-bit read returns the whole register.
- R8: `bus_rvalid` is high in exactly the cycle after a read strobe is sampled. `bus_rdata` then shows the register contents from before any write sampled on that same edge.
- R9: Two byte writes of the low and high halves leave a register equal to a single 16-bit write of the combined value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 10 | Byte address; bits [9:1] select the word, bit 0 selects the lane |
| bus_size | input | 1 | Transfer size: 0 = byte, 1 = 16-bit |
| bus_wdata | input | 16 | Write data; byte writes take bits [7:0] |
| bus_wr | input | 1 | Write strobe, one transfer per sampled cycle |
| bus_rd | input | 1 | Read strobe, one transfer per sampled cycle |
| bus_rdata | output | 16 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read-data valid pulse, one cycle after the read strobe |

## Verification
The hardest case to reach is a write that lands on the correct word with the correct enable while the other lane is quietly clobbered, or a write that lands on an aliased word. Directed tests with clean data usually hide both. The stimulus sweeps every mapped word, several unmapped indices that alias onto mapped ones in their low bits, and both lanes and both sizes. Every byte write carries random data on the unused half of the bus. After each write, a per-register shadow model is compared against byte and word reads of the whole bank, so any stray lane or aliased update shows up in the next read.

// File: rtl/blrb_pkg.sv
package blrb_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_HALF = 1'b1
  } xfer_size_e;

endpackage

// File: rtl/blrb_lane_decode.sv
module blrb_lane_decode
  import blrb_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int NUM_REGS = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                size,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                wr,
  output logic [NUM_REGS-1:0] sel,
  output logic                hit,
  output logic                lane_hi,
  output logic [LANES-1:0]    wr_lane_en,
  output logic [WORD_W-1:0]   lane_wdata
);

  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] word_idx;
  logic             mapped;
  logic             aligned;
  logic [LANES-1:0] lane_en;

  always_comb begin
    word_idx = addr[ADDR_W-1:1];
    lane_hi  = addr[0];
    mapped   = int'(word_idx) < NUM_REGS;
    aligned  = (size == XFER_HALF) ? !addr[0] : 1'b1;
    hit      = mapped && aligned;
    if (size == XFER_HALF) lane_en = '1;
    else                   lane_en = addr[0] ? 2'b10 : 2'b01;
    wr_lane_en = (wr && hit) ? lane_en : '0;
  end

  // Byte writes carry their data on the low half; copy it to every lane.
  always_comb begin
    if (size == XFER_HALF) lane_wdata = wdata;
    else                   lane_wdata = {LANES{wdata[LANE_W-1:0]}};
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel[g] = mapped && (int'(word_idx) == g);
  end

endmodule

// File: rtl/blrb_reg_word.sv
module blrb_reg_word
  import blrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LANES-1:0]  lane_we,
  input  logic [WORD_W-1:0] lane_wdata,
  output logic [WORD_W-1:0] q
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)             q[l*LANE_W +: LANE_W] <= '0;
      else if (lane_we[l]) q[l*LANE_W +: LANE_W] <= lane_wdata[l*LANE_W +: LANE_W];
    end

    // A lane without its enable keeps its byte (R2, R3)
    assert_lane_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !lane_we[l] |=> $stable(q[l*LANE_W +: LANE_W]));

    // An enabled lane takes the presented byte on that edge (R2, R4)
    assert_lane_load_R2: assert property (@(posedge clk) disable iff (rst)
      lane_we[l] |=> q[l*LANE_W +: LANE_W] == $past(lane_wdata[l*LANE_W +: LANE_W]));
  end

endmodule

// File: rtl/blrb_read_mux.sv
module blrb_read_mux
  import blrb_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic [NUM_REGS*WORD_W-1:0] bank,
  input  logic [NUM_REGS-1:0]        sel,
  input  logic                       hit,
  input  logic                       size,
  input  logic                       lane_hi,
  output logic [WORD_W-1:0]          rd_word
);

  logic [WORD_W-1:0] terms [NUM_REGS];
  logic [WORD_W-1:0] picked;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_term
    assign terms[g] = bank[g*WORD_W +: WORD_W] & {WORD_W{sel[g]}};
  end

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_REGS; i++) picked = picked | terms[i];
  end

  always_comb begin
    if (!hit)                   rd_word = '0;
    else if (size == XFER_HALF) rd_word = picked;
    else if (lane_hi)           rd_word = {{(WORD_W-LANE_W){1'b0}}, picked[WORD_W-1 -: LANE_W]};
    else                        rd_word = {{(WORD_W-LANE_W){1'b0}}, picked[LANE_W-1:0]};
  end

endmodule

// File: rtl/blrb_bank.sv
module blrb_bank
  import blrb_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_size,
  input  logic [15:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid
);

  localparam int BANK_W = NUM_REGS * WORD_W;

  logic [NUM_REGS-1:0] sel;
  logic                hit;
  logic                lane_hi;
  logic [LANES-1:0]    wr_lane_en;
  logic [WORD_W-1:0]   lane_wdata;
  logic [BANK_W-1:0]   bank;
  logic [WORD_W-1:0]   rd_word;
  logic [WORD_W-1:0]   rdata_q;
  logic                rvalid_q;

  blrb_lane_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .addr       (bus_addr),
    .size       (bus_size),
    .wdata      (bus_wdata),
    .wr         (bus_wr),
    .sel        (sel),
    .hit        (hit),
    .lane_hi    (lane_hi),
    .wr_lane_en (wr_lane_en),
    .lane_wdata (lane_wdata)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    blrb_reg_word u_word (
      .clk        (clk),
      .rst        (rst),
      .lane_we    (wr_lane_en & {LANES{sel[g]}}),
      .lane_wdata (lane_wdata),
      .q          (bank[g*WORD_W +: WORD_W])
    );
  end

  blrb_read_mux #(.NUM_REGS(NUM_REGS)) u_rmux (
    .bank    (bank),
    .sel     (sel),
    .hit     (hit),
    .size    (bus_size),
    .lane_hi (lane_hi),
    .rd_word (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_word;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  assert_rvalid_follows_rd_R8: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  assert_rvalid_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  assert_misaligned_wr_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_size == XFER_HALF && bus_addr[0]) |=> $stable(bank));

  assert_misaligned_rd_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_size == XFER_HALF && bus_addr[0]) |=> bus_rdata == '0);

  assert_unmapped_wr_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && int'(bus_addr[ADDR_W-1:1]) >= NUM_REGS) |=> $stable(bank));

  assert_unmapped_rd_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr[ADDR_W-1:1]) >= NUM_REGS) |=> bus_rdata == '0);

  assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_size == XFER_BYTE) |=> bus_rdata[15:8] == '0);

endmodule

// File: tb/blrb_bank_tb.sv
`timescale 1ns/1ps
module blrb_bank_tb_top;

  localparam int NREG = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  bus_addr = '0;
  logic        bus_size = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [15:0] shadow [NREG];

  always #4 clk = ~clk;

  blrb_bank dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [9:0] a, input logic sz);
    int w = int'(a[9:1]);
    if (w >= NREG) return 16'h0000;
    if (sz) return a[0] ? 16'h0000 : shadow[w];
    return a[0] ? {8'h00, shadow[w][15:8]} : {8'h00, shadow[w][7:0]};
  endfunction

  // Byte writes put junk on bits [15:8]; the model ignores it.
  task automatic do_write(input logic [9:0] a, input logic sz, input logic [15:0] d);
    int w = int'(a[9:1]);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_wdata = 16'($urandom);
    if (w < NREG) begin
      if (sz && !a[0]) shadow[w] = d;
      else if (!sz && !a[0]) shadow[w][7:0] = d[7:0];
      else if (!sz && a[0]) shadow[w][15:8] = d[7:0];
    end
  endtask

  task automatic do_read(input logic [9:0] a, input logic sz, output logic [15:0] q);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R8 rvalid after read", {15'h0, bus_rvalid}, 16'h0001);
    q = bus_rdata;
  endtask

  task automatic sweep_bank(input string tag);
    logic [15:0] q;
    for (int w = 0; w < NREG; w++) begin
      do_read(10'(w*2), 1'b1, q);
      check({tag, " R7 word read"}, q, shadow[w]);
      do_read(10'(w*2), 1'b0, q);
      check({tag, " R7 low byte read"}, q, {8'h00, shadow[w][7:0]});
      do_read(10'(w*2+1), 1'b0, q);
      check({tag, " R7 high byte read"}, q, {8'h00, shadow[w][15:8]});
    end
  endtask

  initial begin
    logic [15:0] q;
    logic [15:0] d;
    logic [9:0]  a;
    for (int i = 0; i < NREG; i++) shadow[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 rvalid low after reset", {15'h0, bus_rvalid}, 16'h0000);
    sweep_bank("R1");

    // R2, R3: byte writes with random junk on the unused half
    for (int rep = 0; rep < 3; rep++) begin
      for (int w = 0; w < NREG; w++) begin
        for (int lane = 0; lane < 2; lane++) begin
          a = 10'(w*2 + lane);
          d = 16'($urandom);
          do_write(a, 1'b0, d);
          do_read(10'(w*2), 1'b1, q);
          check(lane == 0 ? "R2 low lane write, high kept" : "R3 high lane write, low kept",
                q, shadow[w]);
        end
      end
    end
    sweep_bank("R3");

    // R4: aligned 16-bit writes
    for (int w = 0; w < NREG; w++) begin
      d = 16'($urandom);
      do_write(10'(w*2), 1'b1, d);
      do_read(10'(w*2), 1'b1, q);
      check("R4 full word write", q, d);
    end

    // R5: misaligned 16-bit writes and reads
    for (int w = 0; w < NREG; w++) begin
      do_write(10'(w*2+1), 1'b1, 16'($urandom));
      do_read(10'(w*2+1), 1'b1, q);
      check("R5 misaligned read is zero", q, 16'h0000);
    end
    sweep_bank("R5 no change");

    // R6: unmapped indices, including aliases of mapped ones
    for (int w = NREG; w < 4*NREG; w++) begin
      for (int lane = 0; lane < 2; lane++) begin
        a = 10'(w*2 + lane);
        do_write(a, 1'b0, 16'($urandom));
        do_read(a, 1'b0, q);
        check("R6 unmapped byte read", q, model_read(a, 1'b0));
      end
      do_write(10'(w*2), 1'b1, 16'($urandom));
      do_read(10'(w*2), 1'b1, q);
      check("R6 unmapped word read", q, 16'h0000);
    end
    do_write(10'h3FE, 1'b1, 16'hDEAD);
    do_read(10'h3FE, 1'b1, q);
    check("R6 top index read", q, 16'h0000);
    sweep_bank("R6 no change");

    // R9: split byte writes equal one word write
    for (int w = 0; w + 1 < NREG; w += 2) begin
      d = 16'($urandom);
      do_write(10'(w*2), 1'b0, {8'($urandom), d[7:0]});
      do_write(10'(w*2+1), 1'b0, {8'($urandom), d[15:8]});
      do_write(10'((w+1)*2), 1'b1, d);
      do_read(10'(w*2), 1'b1, q);
      check("R9 split bytes", q, d);
      do_read(10'((w+1)*2), 1'b1, q);
      check("R9 single word", q, d);
    end

    // R8: read and write on the same edge return the old contents
    for (int w = 0; w < NREG; w++) begin
      d = 16'($urandom);
      @(negedge clk);
      bus_addr = 10'(w*2); bus_size = 1'b1; bus_wdata = d;
      bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check("R8 read sees pre-write value", bus_rdata, shadow[w]);
      shadow[w] = d;
      @(negedge clk);
      check("R8 rvalid drops", {15'h0, bus_rvalid}, 16'h0000);
      do_read(10'(w*2), 1'b1, q);
      check("R8 new value after write", q, d);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule